// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Lock

This block is a down-counting interval timer. A programmable clock divider feeds it, and software reaches it through a small 32-bit register bus with byte enables. Software sets a divider and a period and then enables the counter. The counter can run once or reload on every expiry. Each expiry latches an event flag, and that flag can drive an interrupt line.

The same counter can be turned into a watchdog. Once armed, the watchdog cannot be disarmed, stopped or reprogrammed until a hardware reset. Software must write a fixed key byte before the period runs out. If it does not, a reset request pulse of fixed length is driven out, and the count starts over.

Top module: `pwdt_timer`

## Requirements
- R1: Word addresses are 0 for the control word, 1 for the timer setup, 2 for the event status and 3 for the live counter (read-only, bits [15:0]). A write needs req_i and we_i and updates only the bytes whose be_i bit is set. The control state sits in byte 1, so a control write without be_i[1] changes nothing.
- R2: The timer setup holds the divider in bits [31:16] and the period in bits [15:0]. A divider value D from 1 to 65535 gives one counter step every D clocks, and D = 0 gives one step every 65536 clocks.
- R3: Setting control bit 12 while it is clear loads the period. With bit 10 clear, the counter expires D*max(P,1) clocks after that write edge. At expiry, bit 12 clears itself and the live counter stays at 0.
- R4: With control bit 10 set, the counter reloads at each expiry and expires again every D*max(P,1) clocks. Between expiries the live counter reads P - floor(k/D), where k is the number of clocks since the last load.
- R5: Clearing control bit 12 freezes the live counter.
- R6: Each expiry sets status bit 0. Writing 1 to that bit with be_i[0] clears it. An expiry in the same cycle as the clear wins.
- R7: irq_o is high exactly when status bit 0 and control bit 8 are both set.
- R8: Writing control bit 15 as 1 arms the watchdog. Bit 12 reads 1, bits 10 and 8 read 0, and the period restarts. Bit 15 stays set until rst_ni is asserted.
- R9: While bit 15 is set, writes to the timer setup and to control byte 1 are ignored.
- R10: While armed, writing 0xA5 into control bits [31:24] with be_i[3] restarts the divider and the period. Any other byte value has no effect. A key write in the same cycle as an expiry prevents that expiry.
- R11: An unserviced watchdog expiry drives wdt_rst_o high for exactly 16 clocks, starting with the expiry edge. The counter then reloads and keeps running.
- R12: After reset, every register reads 0 and irq_o and wdt_rst_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 2 | Word address |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Expiry interrupt |
| wdt_rst_o | output | 1 | Watchdog reset request |

## Verification
The assertions assume the bus holds steady around each clock edge and that a write lasts exactly one cycle. They also assume rst_ni is the only way out of watchdog mode. The stimulus drives every bus field half a cycle away from the edge and drops req_i right after the write edge. It reads back only through the combinational read port. It never relies on a same-cycle combination of setup write and start, except the watchdog key landing exactly on an expiry edge, which it schedules on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int NBYTE  = DATA_W / 8;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_SETUP  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_LIVE   = 2'd3;

  localparam int MB_IRQ  = 8;
  localparam int MB_CONT = 10;
  localparam int MB_EN   = 12;
  localparam int MB_WD   = 15;
  localparam int KEY_LSB = 24;

  localparam logic [7:0] SERVICE_KEY = 8'hA5;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  // div 0 wraps to all ones: full 2^PRE_W division
  assign last   = div_i - 1'b1;
  assign tick_o = run_i & ~clr_i & (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i & ~load_i & (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= period_i;
    else if (expire_o) cnt_q <= reload_i ? period_i : '0;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (trig_i)  left_q <= CW'(LEN);
    else if (pulse_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/pwdt_timer.sv
module pwdt_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W   = 16,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [NBYTE-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam int PRE_LSB = DATA_W - PRE_W;
  localparam int CTL_BYTE = MB_EN / 8;
  localparam int KEY_BYTE = KEY_LSB / 8;

  logic wd_q, en_q, cont_q, irq_en_q, flag_q;
  logic [DATA_W-1:0] setup_q, be_mask;
  logic wr_en, sel_mode, sel_setup, sel_stat;
  logic mode_b1_wr, svc, arm, start, load, setup_we;
  logic tick, expire, wd_trig;
  logic [CNT_W-1:0] live;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] period;
  logic unused_wdata;

  for (genvar b = 0; b < NBYTE; b++) begin : g_mask
    assign be_mask[8*b +: 8] = {8{be_i[b]}};
  end

  assign unused_wdata = ^wdata_i;

  assign wr_en      = req_i & we_i;
  assign sel_mode   = wr_en & (addr_i == ADDR_MODE);
  assign sel_setup  = wr_en & (addr_i == ADDR_SETUP);
  assign sel_stat   = wr_en & (addr_i == ADDR_STATUS);
  assign mode_b1_wr = sel_mode & be_i[CTL_BYTE];
  assign svc        = sel_mode & be_i[KEY_BYTE] & wd_q
                    & (wdata_i[KEY_LSB +: 8] == SERVICE_KEY);
  assign arm        = mode_b1_wr & ~wd_q & wdata_i[MB_WD];
  assign start      = arm | (mode_b1_wr & ~wd_q & wdata_i[MB_EN] & ~en_q);
  assign load       = start | svc;
  assign setup_we   = sel_setup & ~wd_q;

  assign prescale = setup_q[PRE_LSB +: PRE_W];
  assign period   = setup_q[CNT_W-1:0];

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(load),
    .run_i (en_q),  .div_i (prescale), .tick_o(tick)
  );

  tmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i), .rst_ni(rst_ni), .load_i(load), .tick_i(tick),
    .reload_i(cont_q | wd_q), .period_i(period),
    .cnt_o   (live), .expire_o(expire)
  );

  assign wd_trig = expire & wd_q;

  tmr_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(wd_trig), .pulse_o(wdt_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q <= 1'b0; en_q <= 1'b0; cont_q <= 1'b0; irq_en_q <= 1'b0;
    end else if (arm) begin
      wd_q <= 1'b1; en_q <= 1'b1; cont_q <= 1'b0; irq_en_q <= 1'b0;
    end else if (mode_b1_wr && !wd_q) begin
      en_q     <= wdata_i[MB_EN];
      cont_q   <= wdata_i[MB_CONT];
      irq_en_q <= wdata_i[MB_IRQ];
    end else if (expire && !cont_q && !wd_q) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_q <= 1'b0;
    else if (expire)                          flag_q <= 1'b1;
    else if (sel_stat && be_i[0] && wdata_i[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       setup_q <= '0;
    else if (setup_we) setup_q <= (setup_q & ~be_mask) | (wdata_i & be_mask);
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE: begin
        rdata_o[MB_WD]   = wd_q;
        rdata_o[MB_EN]   = en_q;
        rdata_o[MB_CONT] = cont_q;
        rdata_o[MB_IRQ]  = irq_en_q;
      end
      ADDR_SETUP:  rdata_o = setup_q;
      ADDR_STATUS: rdata_o[0] = flag_q;
      default:     rdata_o[CNT_W-1:0] = live;
    endcase
  end

  assign irq_o = irq_en_q & flag_q;
endmodule

// File: rtl/pwdt_timer_chk.sv
module pwdt_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wd_q,
  input logic        en_q,
  input logic        cont_q,
  input logic        irq_en_q,
  input logic        expire,
  input logic        mode_b1_wr,
  input logic        setup_try,
  input logic [31:0] setup_q,
  input logic        wdt_rst_o
);
  // R8: watchdog mode never leaves without reset
  a_r8_wd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |=> wd_q);

  // R8: interrupt enable held low while armed
  a_r8_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |-> !irq_en_q);

  // R9: setup writes refused while armed
  a_r9_setup_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_q && setup_try) |=> $stable(setup_q));

  // R11: reset request only ever comes from an armed watchdog
  a_r11_rst_needs_wd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> wd_q);

  // R3: single-shot stops itself
  a_r3_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && expire && !cont_q && !wd_q && !mode_b1_wr) |=> !en_q);
endmodule

bind pwdt_timer pwdt_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wd_q      (wd_q),
  .en_q      (en_q),
  .cont_q    (cont_q),
  .irq_en_q  (irq_en_q),
  .expire    (expire),
  .mode_b1_wr(mode_b1_wr),
  .setup_try (req_i & we_i & (addr_i == 2'd1)),
  .setup_q   (setup_q),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/pwdt_timer_tb.sv
module pwdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdt_rst;
  int nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  pwdt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .wdt_rst_o(wdt_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    logic [31:0] d, held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    rd(2'd0, d); check("R12 mode", d, 0);
    rd(2'd1, d); check("R12 setup", d, 0);
    rd(2'd2, d); check("R12 status", d, 0);
    check("R12 outs", {30'd0, irq, wdt_rst}, 0);

    // R1 byte enables: control write without be[1] ignored
    wr(2'd0, 32'h0000_1000, 4'b0001);
    rd(2'd0, d); check("R1 be gate", d, 0);
    wr(2'd1, 32'hFFFF_FFFF, 4'b0100);
    rd(2'd1, d); check("R1 byte write", d, 32'h00FF_0000);

    // R2/R3 single-shot sweep, live counter tracked per cycle
    for (int n = 1; n <= 4; n++) begin
      for (int p = 0; p <= 4; p++) begin
        int e;
        e = n * ((p == 0) ? 1 : p);
        wr(2'd1, {16'(n), 16'(p)}, 4'hF);
        wr(2'd2, 32'd1, 4'b0001);
        wr(2'd0, 32'h0000_1000, 4'b0010);
        for (int k = 1; k <= e; k++) begin
          @(posedge clk); #1;
          rd(2'd2, d); check("R3 flag timing", d, (k == e) ? 1 : 0);
          rd(2'd3, d); check("R2 live count", d, (p == 0) ? 0 : 32'(p - k / n));
        end
        rd(2'd0, d); check("R3 self stop", d, 0);
      end
    end

    // R4 continuous, R6 clear in between
    wr(2'd1, {16'd2, 16'd3}, 4'hF);
    wr(2'd2, 32'd1, 4'b0001);
    wr(2'd0, 32'h0000_1400, 4'b0010);
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #1;
      req = 1'b0; we = 1'b0; be = 4'h0;
      rd(2'd2, d); check("R4 R6 flag", d, (k == 6 || k == 12) ? 1 : 0);
      rd(2'd3, d); check("R4 live", d, 32'(3 - (k % 6) / 2));
      if (k == 6) begin
        addr = 2'd2; wdata = 32'd1; be = 4'b0001; req = 1'b1; we = 1'b1;
      end
    end
    // R5 stop freezes
    wr(2'd0, 32'h0, 4'b0010);
    rd(2'd3, held);
    repeat (6) @(posedge clk); #1;
    rd(2'd3, d); check("R5 frozen", d, held);
    // R7 interrupt gating
    check("R7 irq off", {31'd0, irq}, 0);
    wr(2'd0, 32'h0000_0100, 4'b0010);
    check("R7 irq on", {31'd0, irq}, 1);
    wr(2'd2, 32'd1, 4'b0001);
    check("R7 irq cleared", {31'd0, irq}, 0);
    wr(2'd0, 32'h0, 4'b0010);

    // R2 divider 0 means 65536
    wr(2'd1, {16'd0, 16'd1}, 4'hF);
    wr(2'd0, 32'h0000_1000, 4'b0010);
    repeat (65535) @(posedge clk); #1;
    rd(2'd2, d); check("R2 div0 early", d, 0);
    @(posedge clk); #1;
    rd(2'd2, d); check("R2 div0 expire", d, 1);
    wr(2'd2, 32'd1, 4'b0001);

    // R8 arm watchdog, period 20 at divider 1
    wr(2'd1, {16'd1, 16'd20}, 4'hF);
    wr(2'd0, 32'h0000_9500, 4'b0010);
    rd(2'd0, d); check("R8 armed mode", d, 32'h0000_9000);
    // R9 refused writes
    wr(2'd1, {16'd2, 16'd3}, 4'hF);
    rd(2'd1, d); check("R9 setup locked", d, {16'd1, 16'd20});
    wr(2'd0, 32'h0, 4'b0010);
    rd(2'd0, d); check("R9 mode locked", d, 32'h0000_9000);
    // R10 service at A+3, bad key at A+4
    wr(2'd0, 32'hA500_0000, 4'b1000);
    wr(2'd0, 32'h5A00_0000, 4'b1000);
    for (int k = 1; k <= 19; k++) begin
      @(posedge clk); #1;
      check("R10 R11 rst timing", {31'd0, wdt_rst}, (k == 19) ? 1 : 0);
    end
    rd(2'd2, d); check("R6 wd flag", d, 1);
    // R11 pulse length
    for (int j = 1; j <= 19; j++) begin
      @(posedge clk); #1;
      check("R11 pulse len", {31'd0, wdt_rst}, (j <= 15) ? 1 : 0);
    end
    // R10 key on the expiry edge wins
    wr(2'd0, 32'hA500_0000, 4'b1000);
    for (int m = 1; m <= 19; m++) begin
      @(posedge clk); #1;
      check("R10 key beats expiry", {31'd0, wdt_rst}, 0);
    end
    rd(2'd0, d); check("R8 still armed", d, 32'h0000_9000);

    // R8 R12 only reset leaves watchdog
    rst_n = 1'b0; #20; rst_n = 1'b1; #1;
    rd(2'd0, d); check("R8 R12 reset clears", d, 0);
    rd(2'd1, d); check("R12 setup after", d, 0);
    check("R12 outs after", {30'd0, irq, wdt_rst}, 0);
    summary();
  end
endmodule